// File: doc/BRIEF.md
# Image Sensor Row Sequencer

This block generates the per-line control pulses for a CMOS image sensor with row shift registers. It covers both rolling-shutter and full-frame readout. A start-of-line strobe launches one fixed sequence, timed in system clock cycles. The sequence advances both row pointers, precharges the columns, and connects the row to the columns. It samples the pixel signal level, resets the row, and then samples the reset level, so that downstream logic can form a correlated double-sampled value. In rolling-shutter mode a final reset pulse is steered to the row held by the reset pointer, which starts integration for that row.

Pulse widths come from configuration inputs. The block latches them, together with the mode bits, on the cycle a line is accepted. A start-of-frame strobe arms the frame syncs, and they are issued on the next accepted line only. Row syncs are held for a setup window, derived from the clock period, before the row clocks rise. The column-pointer reset is issued inside the first precharge pulse. A start-of-line strobe that arrives while a sequence runs does not disturb it, and it sets a sticky error flag.

Top module: `rowseq_top`

## Requirements
- R1: After reset, every pulse output is low. `sh_sig` and `sh_rst` are high (hold), `drv_rd` is 1 and `drv_rst` is 0. `busy`, `line_done` and `err_overrun` are 0.
- R2: A `line_start` sampled while idle starts a sequence on the next cycle. The phases run in this order: lead (S cycles), row clock (C), first precharge (P), signal sample (G), second precharge (P), row reset (T), reset-level sample (L), second reset (T, rolling shutter only), done (1). Each letter is the latched width, except S, which is ceil(SYNC_SETUP_PS / CLK_PERIOD_PS).
- R3: `row_sel` is high during signal sample, row reset and reset-level sample only. It is never high in a cycle where `col_pc` is high.
- R4: `sh_sig` is 0 (track) only during signal sample, and `sh_rst` is 0 only during reset-level sample. Both are 1 (hold) at all other times.
- R5: With `mode_roll` = 1, a second reset phase of T cycles follows the reset-level sample. In it `pix_rst` = 1, `row_sel` = 0, `drv_rd` = 0 and `drv_rst` = 1. Without `mode_roll` the second reset phase does not occur.
- R6: `pix_rst` rises in the same cycle that the second precharge falls, and stays high for T cycles.
- R7: With `mode_black` = 1, `pix_rst` is also high for exactly the first precharge phase. Otherwise it is low there.
- R8: While busy, `drv_rd`/`drv_rst` are 1/0 when `mode_roll` = 1, except in the second reset phase. They are 1/1 when only `mode_full` = 1, and 1/0 when neither is set. Rolling shutter takes priority, so the two lines are complementary whenever `mode_roll` = 1.
- R9: On the first line accepted after a `frame_start` pulse, `sync_rd` and `sync_rst` are high through the lead and row-clock phases, which gives S cycles of setup before the row clocks rise. On that line `sync_col` is high through the first precharge. On all other lines these three outputs stay low.
- R10: A configured width of 0 behaves as 1. Widths and mode bits are taken on the cycle a line is accepted, and changes to them during the sequence have no effect on it.
- R11: `line_done` is high for exactly one cycle, directly after the last pulse phase. `busy` is high from the first lead cycle through the done cycle.
- R12: A `line_start` sampled while busy leaves the running sequence unchanged and sets `err_overrun`, which stays set until reset.
- R13: `row_clk_rd` and `row_clk_rst` are identical, and both are high for exactly the C cycles of the row-clock phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Start-of-line strobe |
| frame_start | input | 1 | Start-of-frame strobe, arms the syncs for the next line |
| mode_roll | input | 1 | Rolling-shutter mode |
| mode_full | input | 1 | Full-frame mode, both pointers may drive reset |
| mode_black | input | 1 | Dark reference: reset during the first precharge |
| cfg_clk_w | input | CW | Row clock high width |
| cfg_pc_w | input | CW | Precharge width |
| cfg_sig_w | input | CW | Signal-level sample width |
| cfg_rst_w | input | CW | Pixel reset width |
| cfg_rlv_w | input | CW | Reset-level sample width |
| row_clk_rd | output | 1 | Read-pointer row register clock |
| row_clk_rst | output | 1 | Reset-pointer row register clock |
| row_sel | output | 1 | Row select onto columns |
| col_pc | output | 1 | Column precharge |
| sh_sig | output | 1 | Signal-level track/hold (0 track, 1 hold) |
| sh_rst | output | 1 | Reset-level track/hold (0 track, 1 hold) |
| pix_rst | output | 1 | Pixel reset |
| drv_rd | output | 1 | Read pointer drives reset line |
| drv_rst | output | 1 | Reset pointer drives reset line |
| sync_rd | output | 1 | Read-pointer register sync |
| sync_rst | output | 1 | Reset-pointer register sync |
| sync_col | output | 1 | Column pointer reset |
| busy | output | 1 | Sequence running |
| line_done | output | 1 | One-cycle end-of-line flag |
| err_overrun | output | 1 | Sticky flag for an ignored start-of-line strobe |

## Verification
Every output is decoded from the registered phase, so the whole pattern of a line is due starting in the cycle after the edge that samples `line_start`. From there the outputs follow a fixed count of cycles per phase. The bench therefore builds the full expected per-cycle trace of a line as soon as that edge has passed. It queues the trace and compares one entry per cycle on the falling clock edge, so the first entry meets the first lead cycle and `line_done` meets the entry one cycle after the last pulse. The error flag is due one edge after the stray strobe. It is read once the queue has drained, and by then the remaining trace has already shown whether the running line was disturbed.

// File: rtl/rowseq_pkg.sv
`timescale 1ns/1ps
package rowseq_pkg;

    localparam int unsigned NUM_W = 5;
    localparam int unsigned W_CLK = 0;
    localparam int unsigned W_PC  = 1;
    localparam int unsigned W_SIG = 2;
    localparam int unsigned W_RST = 3;
    localparam int unsigned W_RLV = 4;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_LEAD,
        PH_RCLK,
        PH_PC1,
        PH_SIG,
        PH_PC2,
        PH_RST,
        PH_RLV,
        PH_RST2,
        PH_DONE
    } phase_t;

    typedef struct packed {
        logic roll;
        logic full;
        logic black;
    } mode_t;

    typedef struct packed {
        logic row_clk;
        logic row_sel;
        logic col_pc;
        logic sh_sig;
        logic sh_rst;
        logic pix_rst;
        logic drv_rd;
        logic drv_rst;
        logic sync_row;
        logic sync_col;
        logic busy;
        logic done;
    } pins_t;

    // Setup window in whole clock cycles, rounded up, never below one.
    function automatic int unsigned setup_cycles(input int unsigned period_ps,
                                                 input int unsigned setup_ps);
        int unsigned n;
        n = (setup_ps + period_ps - 1) / period_ps;
        if (n == 0) n = 1;
        return n;
    endfunction

    function automatic phase_t phase_after(input phase_t p, input logic roll);
        case (p)
            PH_LEAD: return PH_RCLK;
            PH_RCLK: return PH_PC1;
            PH_PC1:  return PH_SIG;
            PH_SIG:  return PH_PC2;
            PH_PC2:  return PH_RST;
            PH_RST:  return PH_RLV;
            PH_RLV:  return roll ? PH_RST2 : PH_DONE;
            PH_RST2: return PH_DONE;
            default: return PH_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/rowseq_timer.sv
`timescale 1ns/1ps
module rowseq_timer #(
    parameter int unsigned CNTW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [CNTW-1:0] load_val,
    output logic            last
);

    logic [CNTW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == CNTW'(1));

    AST_TMR_PARKED: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q == '0) |=> (cnt_q == '0)); // R2

    AST_TMR_STEP: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == CNTW'($past(cnt_q) - 1'b1))); // R2

endmodule

// File: rtl/rowseq_ctrl.sv
`timescale 1ns/1ps
module rowseq_ctrl
    import rowseq_pkg::*;
#(
    parameter int unsigned CW    = 8,
    parameter int unsigned SETUP = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      line_start,
    input  logic                      frame_start,
    input  mode_t                     mode_in,
    input  logic [NUM_W-1:0][CW-1:0]  wid_in,
    output phase_t                    phase,
    output mode_t                     mode_q,
    output logic                      frame_q,
    output logic                      err
);

    localparam int unsigned SW   = $clog2(SETUP + 1);
    localparam int unsigned CNTW = (CW > SW) ? CW : SW;

    phase_t                   phase_q, phase_d;
    logic [NUM_W-1:0][CW-1:0] wid_clamp;
    logic [NUM_W-1:0][CW-1:0] wid_q;
    logic                     pend_q;
    logic                     err_q;
    logic                     accept;
    logic                     tmr_load;
    logic [CNTW-1:0]          tmr_val;
    logic                     tmr_last;

    // A zero width is stretched to one cycle.
    for (genvar i = 0; i < NUM_W; i++) begin : g_clamp
        assign wid_clamp[i] = (wid_in[i] == '0) ? CW'(1) : wid_in[i];
    end

    function automatic logic [CNTW-1:0] dur_of(input phase_t p,
                                               input logic [NUM_W-1:0][CW-1:0] w);
        case (p)
            PH_LEAD:         return CNTW'(SETUP);
            PH_RCLK:         return CNTW'(w[W_CLK]);
            PH_PC1, PH_PC2:  return CNTW'(w[W_PC]);
            PH_SIG:          return CNTW'(w[W_SIG]);
            PH_RST, PH_RST2: return CNTW'(w[W_RST]);
            PH_RLV:          return CNTW'(w[W_RLV]);
            PH_DONE:         return CNTW'(1);
            default:         return '0;
        endcase
    endfunction

    assign accept = line_start && (phase_q == PH_IDLE);

    always_comb begin
        phase_d  = phase_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (accept) begin
            phase_d  = PH_LEAD;
            tmr_load = 1'b1;
            tmr_val  = CNTW'(SETUP);
        end else if (phase_q != PH_IDLE && tmr_last) begin
            phase_d  = phase_after(phase_q, mode_q.roll);
            tmr_load = 1'b1;
            tmr_val  = dur_of(phase_d, wid_q);
        end
    end

    rowseq_timer #(.CNTW(CNTW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            mode_q  <= '0;
            wid_q   <= '0;
            frame_q <= 1'b0;
            pend_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            if (accept) begin
                mode_q  <= mode_in;
                wid_q   <= wid_clamp;
                frame_q <= pend_q | frame_start;
                pend_q  <= 1'b0;
            end else if (frame_start) begin
                pend_q  <= 1'b1;
            end
            if (line_start && !accept) begin
                err_q <= 1'b1;
            end
        end
    end

    assign phase = phase_q;
    assign err   = err_q;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q); // R12

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (line_start && phase_q != PH_IDLE && phase_q != PH_LEAD) |=> (phase_q != PH_LEAD)); // R12

    AST_RST2_ROLL_ONLY: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_RST2) |-> mode_q.roll); // R5

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE) |=> ($stable(wid_q) && $stable(mode_q))); // R10

endmodule

// File: rtl/rowseq_decode.sv
`timescale 1ns/1ps
module rowseq_decode
    import rowseq_pkg::*;
#(
    parameter int unsigned SETUP = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  phase_t phase,
    input  mode_t  mode,
    input  logic   frame,
    output pins_t  pins
);

    localparam int unsigned SCW = $clog2(SETUP + 1) + 1;

    always_comb begin
        pins        = '0;
        pins.sh_sig = 1'b1;
        pins.sh_rst = 1'b1;
        pins.drv_rd = 1'b1;
        if (phase != PH_IDLE) begin
            pins.busy    = 1'b1;
            pins.drv_rst = mode.full && !mode.roll;
        end
        case (phase)
            PH_LEAD: begin
                pins.sync_row = frame;
            end
            PH_RCLK: begin
                pins.row_clk  = 1'b1;
                pins.sync_row = frame;
            end
            PH_PC1: begin
                pins.col_pc   = 1'b1;
                pins.pix_rst  = mode.black;
                pins.sync_col = frame;
            end
            PH_SIG: begin
                pins.row_sel = 1'b1;
                pins.sh_sig  = 1'b0;
            end
            PH_PC2: begin
                pins.col_pc = 1'b1;
            end
            PH_RST: begin
                pins.row_sel = 1'b1;
                pins.pix_rst = 1'b1;
            end
            PH_RLV: begin
                pins.row_sel = 1'b1;
                pins.sh_rst  = 1'b0;
            end
            PH_RST2: begin
                pins.pix_rst = 1'b1;
                pins.drv_rd  = 1'b0;
                pins.drv_rst = 1'b1;
            end
            PH_DONE: begin
                pins.done = 1'b1;
            end
            default: ;
        endcase
    end

    // Cycles of row sync seen ahead of the row clock edge.
    logic [SCW-1:0] lead_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lead_q <= '0;
        end else if (pins.sync_row && !pins.row_clk) begin
            if (lead_q != '1) lead_q <= lead_q + 1'b1;
        end else if (!pins.sync_row) begin
            lead_q <= '0;
        end
    end

    AST_PC_SEL_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(pins.col_pc && pins.row_sel)); // R3

    AST_ONE_TRACK: assert property (@(posedge clk) disable iff (rst)
        (pins.sh_sig || pins.sh_rst)); // R4

    AST_RST_AT_PC_FALL: assert property (@(posedge clk) disable iff (rst)
        ($rose(pins.pix_rst) && pins.row_sel) |-> $fell(pins.col_pc)); // R6

    AST_DRV_COMPL: assert property (@(posedge clk) disable iff (rst)
        (pins.busy && mode.roll) |-> (pins.drv_rd ^ pins.drv_rst)); // R8

    AST_SYNC_SETUP: assert property (@(posedge clk) disable iff (rst)
        ($rose(pins.row_clk) && pins.sync_row) |-> (lead_q >= SCW'(SETUP))); // R9

endmodule

// File: rtl/rowseq_top.sv
`timescale 1ns/1ps
module rowseq_top
    import rowseq_pkg::*;
#(
    parameter int unsigned CW            = 8,
    parameter int unsigned CLK_PERIOD_PS = 10000,
    parameter int unsigned SYNC_SETUP_PS = 200000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_start,
    input  logic          frame_start,
    input  logic          mode_roll,
    input  logic          mode_full,
    input  logic          mode_black,
    input  logic [CW-1:0] cfg_clk_w,
    input  logic [CW-1:0] cfg_pc_w,
    input  logic [CW-1:0] cfg_sig_w,
    input  logic [CW-1:0] cfg_rst_w,
    input  logic [CW-1:0] cfg_rlv_w,
    output logic          row_clk_rd,
    output logic          row_clk_rst,
    output logic          row_sel,
    output logic          col_pc,
    output logic          sh_sig,
    output logic          sh_rst,
    output logic          pix_rst,
    output logic          drv_rd,
    output logic          drv_rst,
    output logic          sync_rd,
    output logic          sync_rst,
    output logic          sync_col,
    output logic          busy,
    output logic          line_done,
    output logic          err_overrun
);

    localparam int unsigned SETUP = setup_cycles(CLK_PERIOD_PS, SYNC_SETUP_PS);

    logic [NUM_W-1:0][CW-1:0] wid_in;
    mode_t                    mode_in;
    mode_t                    mode_q;
    phase_t                   phase;
    logic                     frame_q;
    pins_t                    pins;

    assign wid_in[W_CLK] = cfg_clk_w;
    assign wid_in[W_PC]  = cfg_pc_w;
    assign wid_in[W_SIG] = cfg_sig_w;
    assign wid_in[W_RST] = cfg_rst_w;
    assign wid_in[W_RLV] = cfg_rlv_w;

    assign mode_in = '{roll: mode_roll, full: mode_full, black: mode_black};

    rowseq_ctrl #(.CW(CW), .SETUP(SETUP)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .line_start  (line_start),
        .frame_start (frame_start),
        .mode_in     (mode_in),
        .wid_in      (wid_in),
        .phase       (phase),
        .mode_q      (mode_q),
        .frame_q     (frame_q),
        .err         (err_overrun)
    );

    rowseq_decode #(.SETUP(SETUP)) u_decode (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .mode  (mode_q),
        .frame (frame_q),
        .pins  (pins)
    );

    assign row_clk_rd  = pins.row_clk;
    assign row_clk_rst = pins.row_clk;
    assign row_sel     = pins.row_sel;
    assign col_pc      = pins.col_pc;
    assign sh_sig      = pins.sh_sig;
    assign sh_rst      = pins.sh_rst;
    assign pix_rst     = pins.pix_rst;
    assign drv_rd      = pins.drv_rd;
    assign drv_rst     = pins.drv_rst;
    assign sync_rd     = pins.sync_row;
    assign sync_rst    = pins.sync_row;
    assign sync_col    = pins.sync_col;
    assign busy        = pins.busy;
    assign line_done   = pins.done;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        line_done |=> !line_done); // R11

    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        line_done |-> busy); // R11

    AST_COL_SYNC_IN_PC: assert property (@(posedge clk) disable iff (rst)
        sync_col |-> col_pc); // R9

    AST_CLK_PAIR: assert property (@(posedge clk) disable iff (rst)
        row_clk_rd == row_clk_rst); // R13

endmodule

// File: tb/sim_rowseq_top.sv
`timescale 1ns/1ps
module sim_rowseq_top;

    localparam int CLK_PERIOD = 10;
    localparam int CW         = 8;
    localparam int PERIOD_PS  = 50000;
    localparam int SETUP_EXP  = (200000 + PERIOD_PS - 1) / PERIOD_PS;

    typedef struct packed {
        logic row_clk;
        logic row_sel;
        logic col_pc;
        logic sh_sig;
        logic sh_rst;
        logic pix_rst;
        logic drv_rd;
        logic drv_rst;
        logic sync_row;
        logic sync_col;
        logic busy;
        logic done;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          line_start = 1'b0;
    logic          frame_start = 1'b0;
    logic          mode_roll = 1'b0;
    logic          mode_full = 1'b0;
    logic          mode_black = 1'b0;
    logic [CW-1:0] cfg_clk_w = 8'd1;
    logic [CW-1:0] cfg_pc_w  = 8'd1;
    logic [CW-1:0] cfg_sig_w = 8'd1;
    logic [CW-1:0] cfg_rst_w = 8'd1;
    logic [CW-1:0] cfg_rlv_w = 8'd1;
    logic row_clk_rd, row_clk_rst, row_sel, col_pc, sh_sig, sh_rst, pix_rst;
    logic drv_rd, drv_rst, sync_rd, sync_rst, sync_col, busy, line_done, err_overrun;

    int   n_tests = 0;
    int   n_fail  = 0;
    int   cycles  = 0;
    exp_t exp_q[$];
    exp_t mon_e;

    rowseq_top #(.CW(CW), .CLK_PERIOD_PS(PERIOD_PS), .SYNC_SETUP_PS(200000)) u0 (
        .clk(clk), .rst(rst), .line_start(line_start), .frame_start(frame_start),
        .mode_roll(mode_roll), .mode_full(mode_full), .mode_black(mode_black),
        .cfg_clk_w(cfg_clk_w), .cfg_pc_w(cfg_pc_w), .cfg_sig_w(cfg_sig_w),
        .cfg_rst_w(cfg_rst_w), .cfg_rlv_w(cfg_rlv_w),
        .row_clk_rd(row_clk_rd), .row_clk_rst(row_clk_rst), .row_sel(row_sel),
        .col_pc(col_pc), .sh_sig(sh_sig), .sh_rst(sh_rst), .pix_rst(pix_rst),
        .drv_rd(drv_rd), .drv_rst(drv_rst), .sync_rd(sync_rd), .sync_rst(sync_rst),
        .sync_col(sync_col), .busy(busy), .line_done(line_done), .err_overrun(err_overrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input logic act, input logic exp, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", what, act, exp, $time);
        end
    endtask

    function automatic exp_t idle_e();
        exp_t e;
        e        = '0;
        e.sh_sig = 1'b1;
        e.sh_rst = 1'b1;
        e.drv_rd = 1'b1;
        return e;
    endfunction

    task automatic push(input int n, input exp_t e);
        for (int i = 0; i < n; i++) exp_q.push_back(e);
    endtask

    // Monitor: one expected item per cycle, compared away from the edge.
    always @(negedge clk) begin
        if (!rst && exp_q.size() > 0) begin
            mon_e = exp_q.pop_front();
            chk(row_clk_rd,  mon_e.row_clk,  "R13 read-pointer row clock");
            chk(row_clk_rst, mon_e.row_clk,  "R13 reset-pointer row clock");
            chk(row_sel,     mon_e.row_sel,  "R3 row select");
            chk(col_pc,      mon_e.col_pc,   "R2 column precharge");
            chk(sh_sig,      mon_e.sh_sig,   "R4 signal track/hold");
            chk(sh_rst,      mon_e.sh_rst,   "R4 reset-level track/hold");
            chk(pix_rst,     mon_e.pix_rst,  "R6 pixel reset");
            chk(drv_rd,      mon_e.drv_rd,   "R8 read pointer drive");
            chk(drv_rst,     mon_e.drv_rst,  "R8 reset pointer drive");
            chk(sync_rd,     mon_e.sync_row, "R9 read-pointer sync");
            chk(sync_rst,    mon_e.sync_row, "R9 reset-pointer sync");
            chk(sync_col,    mon_e.sync_col, "R9 column sync");
            chk(busy,        mon_e.busy,     "R11 busy");
            chk(line_done,   mon_e.done,     "R11 line done");
        end
    end

    // Driver: start a line and queue its full expected trace.
    task automatic run_line(input int wc, input int wp, input int ws, input int wr,
                            input int wl, input bit roll, input bit full,
                            input bit black, input bit frm, input bit poke);
        exp_t b, e;
        int c, p, s, r, l;
        c = (wc == 0) ? 1 : wc;  // R10: zero acts as one
        p = (wp == 0) ? 1 : wp;
        s = (ws == 0) ? 1 : ws;
        r = (wr == 0) ? 1 : wr;
        l = (wl == 0) ? 1 : wl;
        @(negedge clk);
        cfg_clk_w = CW'(wc); cfg_pc_w = CW'(wp); cfg_sig_w = CW'(ws);
        cfg_rst_w = CW'(wr); cfg_rlv_w = CW'(wl);
        mode_roll = roll; mode_full = full; mode_black = black;
        line_start = 1'b1;
        @(posedge clk);
        #1 line_start = 1'b0;
        b         = idle_e();
        b.busy    = 1'b1;
        b.drv_rst = full && !roll;
        e = b; e.sync_row = frm;                       push(SETUP_EXP, e);
        e.row_clk = 1'b1;                              push(c, e);
        e = b; e.col_pc = 1'b1; e.pix_rst = black;
        e.sync_col = frm;                              push(p, e);  // R7
        e = b; e.row_sel = 1'b1; e.sh_sig = 1'b0;      push(s, e);
        e = b; e.col_pc = 1'b1;                        push(p, e);
        e = b; e.row_sel = 1'b1; e.pix_rst = 1'b1;     push(r, e);  // R6
        e = b; e.row_sel = 1'b1; e.sh_rst = 1'b0;      push(l, e);
        if (roll) begin
            e = b; e.pix_rst = 1'b1; e.drv_rd = 1'b0; e.drv_rst = 1'b1;
            push(r, e);                                              // R5
        end
        e = b; e.done = 1'b1;                          push(1, e);  // R11
        push(2, idle_e());
        if (poke) begin
            repeat (3) @(negedge clk);
            // R12 stray strobe, R10 config and mode changes mid-line
            line_start = 1'b1;
            cfg_clk_w = 8'd9; cfg_pc_w = 8'd9; cfg_sig_w = 8'd9;
            cfg_rst_w = 8'd9; cfg_rlv_w = 8'd9;
            mode_roll = ~roll; mode_black = ~black;
            @(negedge clk);
            line_start = 1'b0;
        end
        wait (exp_q.size() == 0);
        @(negedge clk);
    endtask

    task automatic pulse_frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected at most 100000", cycles);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(row_clk_rd, 1'b0, "R1 row clock low");
        chk(row_sel,    1'b0, "R1 select low");
        chk(col_pc,     1'b0, "R1 precharge low");
        chk(pix_rst,    1'b0, "R1 reset low");
        chk(sh_sig,     1'b1, "R1 signal hold");
        chk(sh_rst,     1'b1, "R1 reset-level hold");
        chk(drv_rd,     1'b1, "R1 read drive");
        chk(drv_rst,    1'b0, "R1 reset drive");
        chk(sync_rd,    1'b0, "R1 sync low");
        chk(busy,       1'b0, "R1 idle");
        chk(line_done,  1'b0, "R1 done low");
        chk(err_overrun,1'b0, "R1 error clear");

        // R2 plain line, no modes
        run_line(2, 3, 2, 2, 3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        // R5 R9 first line of a rolling-shutter frame
        pulse_frame();
        run_line(1, 2, 3, 2, 1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        // R9 following line carries no sync
        run_line(3, 1, 1, 4, 2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        // R8 full-frame drive
        run_line(2, 2, 2, 2, 2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        // R7 reset-black dark reference, with a frame sync
        pulse_frame();
        run_line(2, 4, 1, 3, 1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        // R10 zero widths
        run_line(0, 0, 0, 0, 0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        // R8 rolling overrides full frame
        run_line(1, 1, 2, 1, 2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(err_overrun, 1'b0, "R12 no error after clean lines");
        // R12 R10 stray strobe and config change during a line
        run_line(3, 3, 3, 3, 3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        chk(err_overrun, 1'b1, "R12 error flag set");
        // R12 sticky across a later clean line
        run_line(2, 2, 2, 2, 2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(err_overrun, 1'b1, "R12 error flag sticky");

        summary();
        $finish;
    end

endmodule